// File: doc/BRIEF.md
# Double-Buffered Timekeeping Register Bank

This block is the byte-wide register file that a host bus sees in front of a running timekeeping counter. It holds a host-visible copy of eight time fields: hundredths, seconds, minutes, hours, day, date, month and year. On every 0.01 s update strobe it refreshes that copy from the counter's internal value. Alongside the time copy it stores three alarm bytes, a binary command byte and two watchdog bytes. Addresses above the register window reach a small general-purpose byte store.

Bit 7 of the command byte is the snapshot-enable bit. Clearing it freezes the host-visible time copy while the counter keeps counting, so software can read a consistent snapshot or prepare a new time without racing the refresh. Time bytes written while the copy is frozen are held there. They are handed to the counter as one load when the bit is set again. A time byte written while the bit is set is handed over at once. A write-protect input makes the block ignore all host writes. The counter itself lives outside the block.

Top module: `tk_regbank`

## Requirements
- R1: After reset the command byte (offset 0xB) reads 0x80, all time, alarm, watchdog and storage bytes read 0x00, and `ld_valid_o` is low.
- R2: While command bit 7 is 1, `osc_run_i` is 1 and no load is in progress, an update strobe copies `tk_time_i` into the host-visible time bytes at the next clock edge. Byte k of `tk_time_i` (bits 8k+7..8k) maps to time offset 0x0, 0x1, 0x2, 0x4, 0x6, 0x8, 0x9, 0xA for k = 0..7.
- R3: While command bit 7 is 0, update strobes leave the host-visible time bytes unchanged.
- R4: While `osc_run_i` is 0, update strobes leave the host-visible time bytes unchanged.
- R5: An accepted write to a time offset while command bit 7 is 1 raises `ld_valid_o` for exactly the one cycle after the write. During that cycle `ld_time_o` carries all eight time bytes in the R2 byte order, with the written byte in place.
- R6: A time write while command bit 7 is 0 raises no load, and the written byte reads back at once. A later command write that sets bit 7 raises `ld_valid_o` for the one cycle after it, and `ld_time_o` then carries the held bytes.
- R7: Setting command bit 7 again raises no load when no time byte was written while it was 0.
- R8: While `wp_i` is 1, host writes change no byte anywhere in the map and raise no load.
- R9: Read data appears on `rd_data_o` in the cycle after `rd_en_i` and holds until the next read.
- R10: Offsets 0x3, 0x5, 0x7, 0xC and 0xD, and offsets from 0xE up to 0xE+RAM_BYTES-1, store and return written bytes. Offsets beyond that range read 0x00 and ignore writes.
- R11: An update strobe in the cycle that `ld_valid_o` is high is dropped, so the bytes just handed to the counter are not overwritten by the counter's older value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| addr_i | input | ADDR_W | Host byte address for reads and writes |
| wdata_i | input | 8 | Host write data |
| wr_en_i | input | 1 | Host write strobe |
| rd_en_i | input | 1 | Host read strobe |
| rd_data_o | output | 8 | Registered read data |
| wp_i | input | 1 | Write protect; blocks all host writes |
| tick_i | input | 1 | 0.01 s update strobe from the counter |
| osc_run_i | input | 1 | High while the counter's oscillator runs |
| tk_time_i | input | 64 | Counter's internal time value, eight bytes |
| ld_valid_o | output | 1 | One-cycle load request to the counter |
| ld_time_o | output | 64 | Time bytes to load into the counter |

## Verification
The checker assumes a single host port: one address serves a read or a write in a cycle, and the strobes are never both high. The update strobe is taken to be a one-cycle pulse. The counter is assumed to take `ld_time_o` on the edge that ends a `ld_valid_o` cycle, which is why refresh is suppressed in that cycle. The bench drives every input on the falling edge and keeps reads and writes apart. It pulses the strobe for one cycle and places one strobe deliberately inside a load cycle.

// File: rtl/tk_regbank_pkg.sv
// Package: shared types and offset decode for the timekeeping register bank.
// Assumes the register window occupies offsets 0x0..0xD of the host map.
package tk_regbank_pkg;

    localparam int unsigned NUM_SLOTS = 8;
    localparam int unsigned TIME_W    = 8 * NUM_SLOTS;
    localparam int unsigned REG_SPAN  = 14;
    localparam int unsigned SNAP_BIT  = 7;
    localparam logic [7:0]  CMD_RST   = 8'h80;

    typedef enum logic [2:0] {
        RK_TIME,
        RK_ALARM,
        RK_CMD,
        RK_WDOG,
        RK_RAM,
        RK_NONE
    } reg_kind_e;

    typedef struct packed {
        reg_kind_e  kind;
        logic [2:0] idx;
    } reg_sel_t;

    // Maps an offset inside the register window to its kind and index.
    function automatic reg_sel_t decode_low(input logic [3:0] ofs);
        reg_sel_t s;
        case (ofs)
            4'h0:    s = '{RK_TIME,  3'd0};
            4'h1:    s = '{RK_TIME,  3'd1};
            4'h2:    s = '{RK_TIME,  3'd2};
            4'h3:    s = '{RK_ALARM, 3'd0};
            4'h4:    s = '{RK_TIME,  3'd3};
            4'h5:    s = '{RK_ALARM, 3'd1};
            4'h6:    s = '{RK_TIME,  3'd4};
            4'h7:    s = '{RK_ALARM, 3'd2};
            4'h8:    s = '{RK_TIME,  3'd5};
            4'h9:    s = '{RK_TIME,  3'd6};
            4'hA:    s = '{RK_TIME,  3'd7};
            4'hB:    s = '{RK_CMD,   3'd0};
            4'hC:    s = '{RK_WDOG,  3'd0};
            4'hD:    s = '{RK_WDOG,  3'd1};
            default: s = '{RK_NONE,  3'd0};
        endcase
        return s;
    endfunction

endpackage

// File: rtl/tk_addr_decode.sv
// Module: tk_addr_decode
// Turns a host byte address into a register selector and a storage index.
// Assumes ADDR_W >= 5 and that the register window plus storage fits in
// the address space. Purely combinational.
module tk_addr_decode
    import tk_regbank_pkg::*;
#(
    parameter int unsigned ADDR_W    = 8,
    parameter int unsigned RAM_BYTES = 64,
    localparam int unsigned RAM_AW   = $clog2(RAM_BYTES),
    localparam int unsigned RAM_END  = REG_SPAN + RAM_BYTES
) (
    input  logic [ADDR_W-1:0] addr,
    output reg_sel_t          sel,
    output logic [RAM_AW-1:0] ram_idx
);

    logic [ADDR_W-1:0] ram_ofs;

    // Classify the address as a register, a storage byte or unmapped.
    always_comb begin
        ram_ofs = addr - ADDR_W'(REG_SPAN);
        ram_idx = ram_ofs[RAM_AW-1:0];
        if (addr < ADDR_W'(REG_SPAN)) begin
            sel = decode_low(addr[3:0]);
        end else if ({1'b0, addr} < (ADDR_W + 1)'(RAM_END)) begin
            sel = '{RK_RAM, 3'd0};
        end else begin
            sel = '{RK_NONE, 3'd0};
        end
    end

endmodule

// File: rtl/tk_time_shadow.sv
// Module: tk_time_shadow
// Holds the host-visible copy of the eight time bytes, refreshes it from the
// counter on update strobes while snapshots are enabled, and raises a
// one-cycle load request when host-written bytes must reach the counter.
// Assumes at most one host write per cycle and a counter that takes the
// load on the edge that ends the request cycle.
module tk_time_shadow
    import tk_regbank_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_time,
    input  logic [2:0]        wr_slot,
    input  logic [7:0]        wdata,
    input  logic              snap_en,
    input  logic              snap_rise,
    input  logic              osc_run,
    input  logic              tick,
    input  logic [TIME_W-1:0] tk_time,
    output logic [TIME_W-1:0] ext_flat,
    output logic              ld_valid
);

    logic refresh;
    logic dirty_q;

    // Refresh only with snapshots enabled, a running oscillator and no load pending.
    assign refresh = tick && snap_en && osc_run && !ld_valid;

    for (genvar k = 0; k < NUM_SLOTS; k++) begin : g_slot
        logic [7:0] byte_q;

        // One time byte: a host write wins over a refresh in the same cycle.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                byte_q <= '0;
            end else if (wr_time && (wr_slot == 3'(k))) begin
                byte_q <= wdata;
            end else if (refresh) begin
                byte_q <= tk_time[k*8 +: 8];
            end
        end

        assign ext_flat[k*8 +: 8] = byte_q;
    end

    // Load request and the record of bytes held while the copy is frozen.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ld_valid <= 1'b0;
            dirty_q  <= 1'b0;
        end else begin
            ld_valid <= 1'b0;
            if (wr_time) begin
                if (snap_en) begin
                    ld_valid <= 1'b1;
                end else begin
                    dirty_q <= 1'b1;
                end
            end
            if (snap_rise && dirty_q) begin
                ld_valid <= 1'b1;
                dirty_q  <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/tk_ram.sv
// Module: tk_ram
// Small general-purpose byte store behind the register window.
// Combinational read, synchronous write, cleared on reset.
module tk_ram #(
    parameter int unsigned DEPTH = 64,
    localparam int unsigned AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] idx,
    input  logic [7:0]    wdata,
    output logic [7:0]    rdata
);

    logic [7:0] mem_q [DEPTH];

    // Clear on reset, otherwise store the addressed byte on a write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem_q[i] <= '0;
            end
        end else if (we) begin
            mem_q[idx] <= wdata;
        end
    end

    // Return the addressed byte.
    assign rdata = mem_q[idx];

endmodule

// File: rtl/tk_regbank.sv
// Module: tk_regbank (top)
// Host-facing register bank in front of a timekeeping counter: time copy,
// alarm, command, watchdog and storage bytes, with snapshot freezing and
// load hand-back. Assumes one host port; a read and a write never share a cycle.
module tk_regbank
    import tk_regbank_pkg::*;
#(
    parameter int unsigned ADDR_W    = 8,
    parameter int unsigned RAM_BYTES = 64,
    localparam int unsigned RAM_AW   = $clog2(RAM_BYTES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [7:0]        wdata_i,
    input  logic              wr_en_i,
    input  logic              rd_en_i,
    output logic [7:0]        rd_data_o,
    input  logic              wp_i,
    input  logic              tick_i,
    input  logic              osc_run_i,
    input  logic [TIME_W-1:0] tk_time_i,
    output logic              ld_valid_o,
    output logic [TIME_W-1:0] ld_time_o
);

    reg_sel_t          sel;
    logic [RAM_AW-1:0] ram_idx;
    logic [7:0]        ram_rdata;
    logic [TIME_W-1:0] ext_flat;
    logic              wr_acc;
    logic              wr_time;
    logic              wr_ram;
    logic              snap_rise;
    logic [7:0]        cmd_q;
    logic [7:0]        alm_q [3];
    logic [7:0]        wd_q  [2];
    logic [7:0]        rd_mux;
    logic [7:0]        rd_q;

    tk_addr_decode #(
        .ADDR_W    (ADDR_W),
        .RAM_BYTES (RAM_BYTES)
    ) u_dec (
        .addr    (addr_i),
        .sel     (sel),
        .ram_idx (ram_idx)
    );

    // Qualify host writes with write protect and route them by kind.
    always_comb begin
        wr_acc    = wr_en_i && !wp_i;
        wr_time   = wr_acc && (sel.kind == RK_TIME);
        wr_ram    = wr_acc && (sel.kind == RK_RAM);
        snap_rise = wr_acc && (sel.kind == RK_CMD) && wdata_i[SNAP_BIT] && !cmd_q[SNAP_BIT];
    end

    tk_time_shadow u_shadow (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_time   (wr_time),
        .wr_slot   (sel.idx),
        .wdata     (wdata_i),
        .snap_en   (cmd_q[SNAP_BIT]),
        .snap_rise (snap_rise),
        .osc_run   (osc_run_i),
        .tick      (tick_i),
        .tk_time   (tk_time_i),
        .ext_flat  (ext_flat),
        .ld_valid  (ld_valid_o)
    );

    tk_ram #(
        .DEPTH (RAM_BYTES)
    ) u_ram (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (wr_ram),
        .idx   (ram_idx),
        .wdata (wdata_i),
        .rdata (ram_rdata)
    );

    // Command, alarm and watchdog bytes: plain host storage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_q <= CMD_RST;
            for (int i = 0; i < 3; i++) alm_q[i] <= '0;
            for (int i = 0; i < 2; i++) wd_q[i]  <= '0;
        end else if (wr_acc) begin
            case (sel.kind)
                RK_CMD:   cmd_q <= wdata_i;
                RK_ALARM: alm_q[sel.idx[1:0]] <= wdata_i;
                RK_WDOG:  wd_q[sel.idx[0]]    <= wdata_i;
                default:  ;
            endcase
        end
    end

    // Select the byte addressed by the host.
    always_comb begin
        case (sel.kind)
            RK_TIME:  rd_mux = ext_flat[{sel.idx, 3'b000} +: 8];
            RK_ALARM: rd_mux = alm_q[sel.idx[1:0]];
            RK_CMD:   rd_mux = cmd_q;
            RK_WDOG:  rd_mux = wd_q[sel.idx[0]];
            RK_RAM:   rd_mux = ram_rdata;
            default:  rd_mux = '0;
        endcase
    end

    // Register read data on a read strobe and hold it otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_q <= '0;
        end else if (rd_en_i) begin
            rd_q <= rd_mux;
        end
    end

    assign rd_data_o = rd_q;
    assign ld_time_o = ext_flat;

endmodule

// File: rtl/tk_regbank_chk.sv
// Module: tk_regbank_chk
// Temporal checks on the register bank's ports and its snapshot-enable bit.
// Assumes one-cycle update strobes and no simultaneous read and write.
module tk_regbank_chk
    import tk_regbank_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en_i,
    input logic              rd_en_i,
    input logic              wp_i,
    input logic              tick_i,
    input logic              osc_run_i,
    input logic [TIME_W-1:0] tk_time_i,
    input logic [7:0]        rd_data_o,
    input logic              ld_valid_o,
    input logic [TIME_W-1:0] ld_time_o,
    input logic              snap_en
);

    logic wr_acc;
    assign wr_acc = wr_en_i && !wp_i;

    AST_REFRESH_COPIES: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_i && snap_en && osc_run_i && !ld_valid_o && !wr_acc) |=> (ld_time_o == $past(tk_time_i))); // R2

    AST_FROZEN_WHEN_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
        (!snap_en && !wr_acc) |=> $stable(ld_time_o)); // R3

    AST_FROZEN_WHEN_OSC_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (!osc_run_i && !wr_acc) |=> $stable(ld_time_o)); // R4

    AST_LOAD_FOLLOWS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        ld_valid_o |-> $past(wr_en_i && !wp_i)); // R5

    AST_PROTECT_NO_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        wp_i |=> !ld_valid_o); // R8

    AST_READ_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en_i |=> $stable(rd_data_o)); // R9

    AST_LOAD_CYCLE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_valid_o && !wr_acc) |=> $stable(ld_time_o)); // R11

endmodule

bind tk_regbank tk_regbank_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en_i    (wr_en_i),
    .rd_en_i    (rd_en_i),
    .wp_i       (wp_i),
    .tick_i     (tick_i),
    .osc_run_i  (osc_run_i),
    .tk_time_i  (tk_time_i),
    .rd_data_o  (rd_data_o),
    .ld_valid_o (ld_valid_o),
    .ld_time_o  (ld_time_o),
    .snap_en    (cmd_q[7])
);

// File: tb/tk_regbank_bench.sv
// Directed bench for tk_regbank: one task per scenario, each checking itself.
module tk_regbank_bench;

    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W     = 8;
    localparam int RAM_BYTES  = 64;

    logic              clk = 1'b0;
    logic              rst_n;
    logic [ADDR_W-1:0] addr_i;
    logic [7:0]        wdata_i;
    logic              wr_en_i;
    logic              rd_en_i;
    logic [7:0]        rd_data_o;
    logic              wp_i;
    logic              tick_i;
    logic              osc_run_i;
    logic [63:0]       tk_time_i;
    logic              ld_valid_o;
    logic [63:0]       ld_time_o;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    // Time offset of each byte slot, per R2.
    logic [7:0] slot_ofs [8] = '{8'h0, 8'h1, 8'h2, 8'h4, 8'h6, 8'h8, 8'h9, 8'hA};

    localparam logic [63:0] T1 = 64'h2406_1503_1142_3717;
    localparam logic [63:0] T2 = 64'h2507_1604_2253_4828;
    localparam logic [63:0] T3 = 64'h2608_1705_0301_5939;
    localparam logic [63:0] T4 = 64'h2709_1806_1415_0044;

    tk_regbank #(
        .ADDR_W    (ADDR_W),
        .RAM_BYTES (RAM_BYTES)
    ) u_tk_regbank (
        .clk        (clk),
        .rst_n      (rst_n),
        .addr_i     (addr_i),
        .wdata_i    (wdata_i),
        .wr_en_i    (wr_en_i),
        .rd_en_i    (rd_en_i),
        .rd_data_o  (rd_data_o),
        .wp_i       (wp_i),
        .tick_i     (tick_i),
        .osc_run_i  (osc_run_i),
        .tk_time_i  (tk_time_i),
        .ld_valid_o (ld_valid_o),
        .ld_time_o  (ld_time_o)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic check(input string req, input logic [63:0] got, input logic [63:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fails++;
            $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
        end
    endtask

    task automatic host_wr(input logic [7:0] a, input logic [7:0] d,
                           output logic saw_ld, output logic [63:0] ld_val);
        @(negedge clk);
        addr_i = a; wdata_i = d; wr_en_i = 1'b1;
        @(negedge clk);
        wr_en_i = 1'b0;
        saw_ld = ld_valid_o;
        ld_val = ld_time_o;
    endtask

    task automatic host_rd(input logic [7:0] a, output logic [7:0] d);
        @(negedge clk);
        addr_i = a; rd_en_i = 1'b1;
        @(negedge clk);
        rd_en_i = 1'b0;
        d = rd_data_o;
    endtask

    task automatic pulse_tick(input logic [63:0] t);
        @(negedge clk);
        tk_time_i = t; tick_i = 1'b1;
        @(negedge clk);
        tick_i = 1'b0;
    endtask

    task automatic t_reset;
        logic [7:0] d;
        check("R1 ld_valid", 64'(ld_valid_o), 64'h0);
        host_rd(8'h0B, d); check("R1 command", 64'(d), 64'h80);
        host_rd(8'h01, d); check("R1 seconds", 64'(d), 64'h00);
        host_rd(8'h0C, d); check("R1 watchdog", 64'(d), 64'h00);
        host_rd(8'h20, d); check("R1 storage", 64'(d), 64'h00);
    endtask

    task automatic t_refresh;
        logic [7:0] d;
        pulse_tick(T1);
        for (int k = 0; k < 8; k++) begin
            host_rd(slot_ofs[k], d);
            check("R2 refresh", 64'(d), 64'(T1[k*8 +: 8]));
        end
        repeat (2) @(negedge clk);
        check("R9 read held", 64'(rd_data_o), 64'(T1[63:56]));
    endtask

    task automatic t_freeze_snapshot;
        logic sl; logic [63:0] lv; logic [7:0] d;
        host_wr(8'h0B, 8'h00, sl, lv);
        check("R7 no load on clear", 64'(sl), 64'h0);
        pulse_tick(T2);
        host_rd(8'h00, d); check("R3 frozen byte0", 64'(d), 64'(T1[7:0]));
        host_rd(8'h0A, d); check("R3 frozen year", 64'(d), 64'(T1[63:56]));
    endtask

    task automatic t_held_write;
        logic sl; logic [63:0] lv, exp; logic [7:0] d;
        host_wr(8'h02, 8'h45, sl, lv);
        check("R6 no load while frozen", 64'(sl), 64'h0);
        host_rd(8'h02, d); check("R6 held readback", 64'(d), 64'h45);
        host_wr(8'h0B, 8'h80, sl, lv);
        exp = T1; exp[23:16] = 8'h45;
        check("R6 load on re-enable", 64'(sl), 64'h1);
        check("R6 load value", lv, exp);
        @(negedge clk);
        check("R6 load one cycle", 64'(ld_valid_o), 64'h0);
    endtask

    task automatic t_no_dirty;
        logic sl; logic [63:0] lv;
        host_wr(8'h0B, 8'h00, sl, lv);
        host_wr(8'h0B, 8'h80, sl, lv);
        check("R7 no load without writes", 64'(sl), 64'h0);
    endtask

    task automatic t_live_write;
        logic sl; logic [63:0] lv, exp; logic [7:0] d;
        host_wr(8'h08, 8'h31, sl, lv);
        exp = T1; exp[23:16] = 8'h45; exp[47:40] = 8'h31;
        check("R5 load pulse", 64'(sl), 64'h1);
        check("R5 load value", lv, exp);
        @(negedge clk);
        check("R5 load one cycle", 64'(ld_valid_o), 64'h0);
        // Write month, then strobe during the load cycle.
        @(negedge clk);
        addr_i = 8'h09; wdata_i = 8'h12; wr_en_i = 1'b1;
        @(negedge clk);
        wr_en_i = 1'b0; tk_time_i = T3; tick_i = 1'b1;
        check("R5 load after month write", 64'(ld_valid_o), 64'h1);
        @(negedge clk);
        tick_i = 1'b0;
        host_rd(8'h09, d); check("R11 strobe dropped in load cycle", 64'(d), 64'h12);
        host_rd(8'h00, d); check("R11 other byte kept", 64'(d), 64'(T1[7:0]));
    endtask

    task automatic t_osc_stop;
        logic [7:0] d;
        osc_run_i = 1'b0;
        pulse_tick(T4);
        host_rd(8'h00, d); check("R4 frozen with oscillator off", 64'(d), 64'(T1[7:0]));
        osc_run_i = 1'b1;
        pulse_tick(T4);
        host_rd(8'h00, d); check("R2 refresh resumes", 64'(d), 64'(T4[7:0]));
    endtask

    task automatic t_protect;
        logic sl; logic [63:0] lv; logic [7:0] d;
        wp_i = 1'b1;
        host_wr(8'h00, 8'h99, sl, lv);
        check("R8 no load when protected", 64'(sl), 64'h0);
        host_wr(8'h0B, 8'h00, sl, lv);
        host_wr(8'h03, 8'h12, sl, lv);
        host_wr(8'h20, 8'h55, sl, lv);
        wp_i = 1'b0;
        host_rd(8'h00, d); check("R8 time byte kept", 64'(d), 64'(T4[7:0]));
        host_rd(8'h0B, d); check("R8 command kept", 64'(d), 64'h80);
        host_rd(8'h03, d); check("R8 alarm kept", 64'(d), 64'h00);
        host_rd(8'h20, d); check("R8 storage kept", 64'(d), 64'h00);
    endtask

    task automatic t_storage;
        logic sl; logic [63:0] lv; logic [7:0] d;
        host_wr(8'h03, 8'h30, sl, lv);
        host_wr(8'h05, 8'h23, sl, lv);
        host_wr(8'h07, 8'h86, sl, lv);
        host_wr(8'h0C, 8'h47, sl, lv);
        host_wr(8'h0D, 8'h09, sl, lv);
        host_wr(8'h0E, 8'hA5, sl, lv);
        host_wr(8'h4D, 8'h3C, sl, lv);
        host_wr(8'h4E, 8'h77, sl, lv);
        host_rd(8'h03, d); check("R10 alarm 3", 64'(d), 64'h30);
        host_rd(8'h05, d); check("R10 alarm 5", 64'(d), 64'h23);
        host_rd(8'h07, d); check("R10 alarm 7", 64'(d), 64'h86);
        host_rd(8'h0C, d); check("R10 watchdog C", 64'(d), 64'h47);
        host_rd(8'h0D, d); check("R10 watchdog D", 64'(d), 64'h09);
        host_rd(8'h0E, d); check("R10 first storage", 64'(d), 64'hA5);
        host_rd(8'h4D, d); check("R10 last storage", 64'(d), 64'h3C);
        host_rd(8'h4E, d); check("R10 unmapped", 64'(d), 64'h00);
    endtask

    initial begin
        rst_n = 1'b0; addr_i = '0; wdata_i = '0; wr_en_i = 1'b0; rd_en_i = 1'b0;
        wp_i = 1'b0; tick_i = 1'b0; osc_run_i = 1'b1; tk_time_i = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset;
        t_refresh;
        t_freeze_snapshot;
        t_held_write;
        t_no_dirty;
        t_live_write;
        t_osc_stop;
        t_protect;
        t_storage;
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 20000);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
            $finish;
        end
    end

endmodule